// File: doc/BRIEF.md
# Threshold-Zoned General Register File

This block holds 256 general registers of 64 bits each, one bank shared by integer and floating-point data. Two runtime limits divide the register numbers into three zones. Numbers below the local limit are local registers. Numbers at or above the global base are global registers. Numbers in between are marginal. Local and global registers behave like ordinary storage. A marginal register always reads as zero.

Writing a marginal register moves it into the local zone. The local limit grows to one past the written number. Every register uncovered by that growth reads zero from then on, even if it held data before. The zero-fill takes place on the same clock edge as the write and needs no extra cycles. It works by clearing a per-entry valid bit. An entry whose valid bit is clear reads as zero.

Software sets the two limits through a put port and reads them back through two limit outputs. Puts that would break the ordering of the zones are dropped, and an error output reports them. There are two combinational read ports and one write port. All of them resolve register numbers against the limits that hold before the next clock edge.

Top module: `wrf_zoned_regfile`

## Requirements
- R1: After synchronous reset the local limit is 0, the global base is 255, and every register reads zero.
- R2: A write to a register below the local limit is readable on both read ports from the next cycle on, and it leaves both limits unchanged.
- R3: A write to a register at or above the global base is readable from the next cycle on, and it leaves both limits unchanged.
- R4: A read of a register number from the local limit up to the global base minus one returns zero, whatever was last written there.
- R5: A write to marginal register R sets the local limit to R+1 on the next cycle, and R then reads the written data.
- R6: When a marginal write grows the local limit from old value L to R+1, the registers L to R-1 read zero afterwards.
- R7: A put with put_sel=1 sets the global base on the next cycle when the value is at least 32 and at least the local limit. Registers that become global because the base was lowered read zero.
- R8: A put with put_sel=1 whose value is below 32 or below the local limit leaves the global base unchanged. put_err is then high for exactly the one cycle after the put.
- R9: A put with put_sel=0 sets the local limit to the value when the value is at most the current local limit. A larger value is ignored and raises put_err. Registers between the new and old limit read zero.
- R10: When a read port and the write port address the same register in one cycle, the read returns the value held before the write. The new value appears after the clock edge.
- R11: A put asserted in the same cycle as wr_en is ignored and raises put_err. The write still takes effect.
- R12: The local limit never exceeds the global base, and the global base never falls below 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd0_addr | input | 8 | Register number for read port 0 |
| rd0_data | output | 64 | Read port 0 data, combinational |
| rd1_addr | input | 8 | Register number for read port 1 |
| rd1_data | output | 64 | Read port 1 data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Register number to write |
| wr_data | input | 64 | Data to write |
| put_en | input | 1 | Limit put enable |
| put_sel | input | 1 | Put target: 0 = local limit, 1 = global base |
| put_val | input | 8 | Value to put |
| local_lim | output | 8 | Current local limit |
| global_base | output | 8 | Current global base |
| put_err | output | 1 | Pulses for one cycle after a rejected put |

## Verification
A read of a register and a write to that same register can fall in the same cycle. The case matters most when the register is marginal, because the write then also moves the local limit. The bench sets one read port and the write port to the same number in the same cycle. It samples the read port before the clock edge, where it expects the old value, or zero for a marginal register. It samples again after the edge, where it expects the new data and a local limit one past the written number. A put that arrives together with a write is covered in the same way, by checking that the write lands and the limit does not move.

// File: rtl/rfw_pkg.sv
package rfw_pkg;

  typedef enum logic [1:0] {
    ZN_LOCAL  = 2'd0,
    ZN_MARGIN = 2'd1,
    ZN_GLOBAL = 2'd2
  } zone_e;

  // zone of a register number for given local limit and global base
  function automatic zone_e zone_of(input logic [31:0] idx,
                                    input logic [31:0] lim,
                                    input logic [31:0] base);
    if (idx >= base)     return ZN_GLOBAL;
    else if (idx < lim)  return ZN_LOCAL;
    else                 return ZN_MARGIN;
  endfunction

  // half-open span membership: lo <= idx < hi
  function automatic logic in_span(input logic [31:0] idx,
                                   input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (idx >= lo) && (idx < hi);
  endfunction

  // local limit after a marginal write to register r
  function automatic logic [31:0] grown_limit(input logic [31:0] r);
    return r + 32'd1;
  endfunction

  // a global-base put is legal when it respects the floor and the local limit
  function automatic logic base_put_legal(input logic [31:0] val,
                                          input logic [31:0] lim,
                                          input logic [31:0] floor_v);
    return (val >= floor_v) && (val >= lim);
  endfunction

  // a local-limit put may only shrink or keep the local zone
  function automatic logic lim_put_legal(input logic [31:0] val,
                                         input logic [31:0] lim);
    return val <= lim;
  endfunction

endpackage

// File: rtl/rfw_zone_decode.sv
module rfw_zone_decode
  import rfw_pkg::*;
#(
  parameter int AW = 8,
  parameter int NP = 3
) (
  input  logic [AW-1:0] addr [NP],
  input  logic [AW-1:0] lim,
  input  logic [AW-1:0] base,
  output zone_e         zone [NP]
);

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign zone[p] = zone_of(32'(addr[p]), 32'(lim), 32'(base));
  end

endmodule

// File: rtl/rfw_thresholds.sv
module rfw_thresholds
  import rfw_pkg::*;
#(
  parameter int AW   = 8,
  parameter int GMIN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  zone_e         wr_zone,
  input  logic          put_en,
  input  logic          put_sel,
  input  logic [AW-1:0] put_val,
  output logic [AW-1:0] lim,
  output logic [AW-1:0] base,
  output logic          put_err,
  output logic          grow,
  output logic          put_ok,
  output logic          clr_en,
  output logic [AW-1:0] clr_lo,
  output logic [AW-1:0] clr_hi
);

  localparam logic [AW-1:0] BASE_RST = AW'((1 << AW) - 1);
  localparam logic [AW-1:0] FLOOR    = AW'(GMIN);

  logic          put_ok_l, put_ok_g, put_bad;
  logic [AW-1:0] lim_n, base_n;

  assign grow     = wr_en && (wr_zone == ZN_MARGIN);
  assign put_ok_l = put_en && !put_sel && !wr_en
                    && lim_put_legal(32'(put_val), 32'(lim));
  assign put_ok_g = put_en && put_sel && !wr_en
                    && base_put_legal(32'(put_val), 32'(lim), 32'(FLOOR));
  assign put_ok   = put_ok_l || put_ok_g;
  assign put_bad  = put_en && !put_ok;

  always_comb begin
    lim_n  = lim;
    base_n = base;
    clr_en = 1'b0;
    clr_lo = lim;
    clr_hi = lim;
    if (grow) begin
      lim_n  = AW'(grown_limit(32'(wr_addr)));
      clr_en = 1'b1;
      clr_lo = lim;
      clr_hi = wr_addr;
    end else if (put_ok_l) begin
      lim_n = put_val;
    end else if (put_ok_g) begin
      base_n = put_val;
      if (put_val < base) begin
        clr_en = 1'b1;
        clr_lo = put_val;
        clr_hi = base;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim     <= '0;
      base    <= BASE_RST;
      put_err <= 1'b0;
    end else begin
      lim     <= lim_n;
      base    <= base_n;
      put_err <= put_bad;
    end
  end

  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lim == '0) && (base == BASE_RST));

  assert_zone_order_R12: assert property (@(posedge clk) disable iff (rst)
    (lim <= base) && (base >= FLOOR));

  assert_marginal_grow_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_zone == ZN_MARGIN) |=> (lim == $past(wr_addr) + AW'(1)));

  assert_low_base_rejected_R8: assert property (@(posedge clk) disable iff (rst)
    (put_en && put_sel && put_val < FLOOR) |=> (put_err && $stable(base)));

  assert_put_write_collide_R11: assert property (@(posedge clk) disable iff (rst)
    (put_en && wr_en) |=> put_err);

endmodule

// File: rtl/rfw_storage.sv
module rfw_storage
  import rfw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 64,
  parameter int NR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_lo,
  input  logic [AW-1:0] clr_hi,
  input  logic [AW-1:0] rd_addr [NR],
  input  zone_e         rd_zone [NR],
  output logic [DW-1:0] rd_data [NR]
);

  localparam int NREGS = 1 << AW;

  logic [DW-1:0]    mem [NREGS];
  logic [NREGS-1:0] valid;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst)
        valid[i] <= 1'b0;
      else if (wr_en && wr_addr == AW'(i))
        valid[i] <= 1'b1;
      else if (clr_en && in_span(32'(i), 32'(clr_lo), 32'(clr_hi)))
        valid[i] <= 1'b0;
    end
  end

  for (genvar p = 0; p < NR; p++) begin : g_rd
    assign rd_data[p] = (rd_zone[p] != ZN_MARGIN && valid[rd_addr[p]])
                        ? mem[rd_addr[p]] : '0;

    assert_marginal_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_zone[p] == ZN_MARGIN) |-> (rd_data[p] == '0));
  end

  assert_fill_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_lo < clr_hi && !(wr_en && wr_addr == clr_lo))
      |=> !valid[$past(clr_lo)]);

  assert_write_valid_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid[$past(wr_addr)]);

endmodule

// File: rtl/wrf_zoned_regfile.sv
module wrf_zoned_regfile
  import rfw_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 64,
  parameter int GMIN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd0_addr,
  output logic [DW-1:0] rd0_data,
  input  logic [AW-1:0] rd1_addr,
  output logic [DW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          put_en,
  input  logic          put_sel,
  input  logic [AW-1:0] put_val,
  output logic [AW-1:0] local_lim,
  output logic [AW-1:0] global_base,
  output logic          put_err
);

  localparam int NRD = 2;
  localparam int NDEC = NRD + 1;

  logic [AW-1:0] dec_addr [NDEC];
  zone_e         dec_zone [NDEC];
  logic [AW-1:0] rd_addr  [NRD];
  zone_e         rd_zone  [NRD];
  logic [DW-1:0] rd_data  [NRD];

  // named internal events for assertions and debug
  logic          ev_grow, ev_put_ok, ev_clear;
  logic [AW-1:0] clr_lo, clr_hi;

  assign rd_addr[0]  = rd0_addr;
  assign rd_addr[1]  = rd1_addr;
  assign dec_addr[0] = rd0_addr;
  assign dec_addr[1] = rd1_addr;
  assign dec_addr[2] = wr_addr;
  assign rd_zone[0]  = dec_zone[0];
  assign rd_zone[1]  = dec_zone[1];
  assign rd0_data    = rd_data[0];
  assign rd1_data    = rd_data[1];

  rfw_zone_decode #(.AW(AW), .NP(NDEC)) u_decode (
    .addr (dec_addr),
    .lim  (local_lim),
    .base (global_base),
    .zone (dec_zone)
  );

  rfw_thresholds #(.AW(AW), .GMIN(GMIN)) u_limits (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_zone (dec_zone[2]),
    .put_en  (put_en),
    .put_sel (put_sel),
    .put_val (put_val),
    .lim     (local_lim),
    .base    (global_base),
    .put_err (put_err),
    .grow    (ev_grow),
    .put_ok  (ev_put_ok),
    .clr_en  (ev_clear),
    .clr_lo  (clr_lo),
    .clr_hi  (clr_hi)
  );

  rfw_storage #(.AW(AW), .DW(DW), .NR(NRD)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .clr_en  (ev_clear),
    .clr_lo  (clr_lo),
    .clr_hi  (clr_hi),
    .rd_addr (rd_addr),
    .rd_zone (rd_zone),
    .rd_data (rd_data)
  );

  assert_put_needs_idle_R11: assert property (@(posedge clk) disable iff (rst)
    ev_put_ok |-> !wr_en);

  assert_nonmarginal_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ev_grow && !put_en) |=> $stable(local_lim) && $stable(global_base));

endmodule

// File: tb/test_wrf_zoned_regfile.sv
`timescale 1ns/1ps
module test_wrf_zoned_regfile;

  localparam int AW = 8;
  localparam int DW = 64;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PL = 3'd2,
                         OP_PG = 3'd3, OP_CL = 3'd4, OP_CG = 3'd5;

  localparam logic [63:0] DA = 64'hA5A5_0000_0000_00FF;
  localparam logic [63:0] DB = 64'h1111_2222_3333_4444;
  localparam logic [63:0] DC = 64'hC0DE_C0DE_0000_0001;
  localparam logic [63:0] DD = 64'hDDDD_0000_DDDD_0000;
  localparam logic [63:0] DE = 64'hE0E0_E0E0_1234_5678;
  localparam logic [63:0] DF = 64'hFFFF_0000_0000_F00F;
  localparam logic [63:0] DG = 64'h6060_6060_6060_6060;
  localparam logic [63:0] Z  = 64'd0;

  // fields: req[142:139] op[138:136] addr[135:128] data[127:64] exp[63:0]
  localparam int NV = 42;
  localparam logic [142:0] VEC [NV] = '{
    {4'd1,  OP_CL, 8'd0,   Z,  64'd0},    // R1 local limit 0
    {4'd1,  OP_CG, 8'd0,   Z,  64'd255},  // R1 global base 255
    {4'd1,  OP_RD, 8'd5,   Z,  Z},        // R1 reads zero
    {4'd3,  OP_WR, 8'd255, DA, Z},        // R3 global write
    {4'd3,  OP_RD, 8'd255, Z,  DA},       // R3
    {4'd5,  OP_WR, 8'd3,   DB, Z},        // R5 marginal write
    {4'd5,  OP_CL, 8'd0,   Z,  64'd4},    // R5 limit R+1
    {4'd5,  OP_RD, 8'd3,   Z,  DB},       // R5
    {4'd6,  OP_RD, 8'd0,   Z,  Z},        // R6 zero-filled
    {4'd6,  OP_RD, 8'd2,   Z,  Z},        // R6
    {4'd2,  OP_WR, 8'd1,   DC, Z},        // R2 local write
    {4'd2,  OP_RD, 8'd1,   Z,  DC},       // R2
    {4'd2,  OP_CL, 8'd0,   Z,  64'd4},    // R2 limit unchanged
    {4'd9,  OP_PL, 8'd2,   Z,  Z},        // R9 shrink limit
    {4'd9,  OP_CL, 8'd0,   Z,  64'd2},    // R9
    {4'd4,  OP_RD, 8'd3,   Z,  Z},        // R4 now marginal
    {4'd2,  OP_RD, 8'd1,   Z,  DC},       // R2 still local
    {4'd5,  OP_WR, 8'd5,   DD, Z},        // R5 grow to 6
    {4'd6,  OP_RD, 8'd3,   Z,  Z},        // R6 old data hidden
    {4'd5,  OP_RD, 8'd5,   Z,  DD},       // R5
    {4'd9,  OP_PL, 8'd7,   Z,  Z},        // R9 grow by put ignored
    {4'd9,  OP_CL, 8'd0,   Z,  64'd6},    // R9
    {4'd7,  OP_PG, 8'd200, Z,  Z},        // R7 legal base
    {4'd7,  OP_CG, 8'd0,   Z,  64'd200},  // R7
    {4'd4,  OP_RD, 8'd210, Z,  Z},        // R4/R7 fresh global zero
    {4'd3,  OP_WR, 8'd210, DE, Z},        // R3
    {4'd3,  OP_RD, 8'd210, Z,  DE},       // R3
    {4'd3,  OP_CL, 8'd0,   Z,  64'd6},    // R3 limit unchanged
    {4'd8,  OP_PG, 8'd20,  Z,  Z},        // R8 below floor
    {4'd8,  OP_CG, 8'd0,   Z,  64'd200},  // R8
    {4'd5,  OP_WR, 8'd99,  DF, Z},        // R5 grow to 100
    {4'd8,  OP_PG, 8'd50,  Z,  Z},        // R8 below local limit
    {4'd8,  OP_CG, 8'd0,   Z,  64'd200},  // R8
    {4'd7,  OP_PG, 8'd150, Z,  Z},        // R7 lower base
    {4'd7,  OP_CG, 8'd0,   Z,  64'd150},  // R7
    {4'd7,  OP_RD, 8'd160, Z,  Z},        // R7 newly global reads zero
    {4'd7,  OP_RD, 8'd210, Z,  DE},       // R7 old global kept
    {4'd3,  OP_RD, 8'd255, Z,  DA},       // R3
    {4'd5,  OP_WR, 8'd120, DG, Z},        // R5 grow to 121
    {4'd6,  OP_RD, 8'd110, Z,  Z},        // R6
    {4'd6,  OP_RD, 8'd99,  Z,  DF},       // R6 below old limit kept
    {4'd12, OP_CL, 8'd0,   Z,  64'd121}   // R12 limit below base
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, wr_addr = '0, put_val = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en = 1'b0, put_en = 1'b0, put_sel = 1'b0;
  logic [DW-1:0] rd0_data, rd1_data;
  logic [AW-1:0] local_lim, global_base;
  logic          put_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wrf_zoned_regfile #(.AW(AW), .DW(DW), .GMIN(32)) i_wrf_zoned_regfile (
    .clk(clk), .rst(rst),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .put_en(put_en), .put_sel(put_sel), .put_val(put_val),
    .local_lim(local_lim), .global_base(global_base), .put_err(put_err)
  );

  task automatic check(input int req, input logic [63:0] got,
                       input logic [63:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic do_put(input logic sel, input logic [7:0] v);
    @(negedge clk);
    put_en = 1'b1; put_sel = sel; put_val = v;
    @(negedge clk);
    put_en = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;

    for (int k = 0; k < NV; k++) begin
      logic [3:0]  req;
      logic [2:0]  op;
      logic [7:0]  a;
      logic [63:0] d, e;
      {req, op, a, d, e} = VEC[k];
      case (op)
        OP_WR: do_write(a, d);
        OP_PL: do_put(1'b0, a);
        OP_PG: do_put(1'b1, a);
        OP_RD: begin
          rd0_addr = a; rd1_addr = a; #1;
          check(int'(req), rd0_data, e, "vector read port 0");
          check(int'(req), rd1_data, e, "vector read port 1");
        end
        OP_CL: check(int'(req), 64'(local_lim), e, "vector local limit");
        default: check(int'(req), 64'(global_base), e, "vector global base");
      endcase
    end

    // R8: rejected put pulses put_err for exactly one cycle
    do_put(1'b1, 8'd10);
    check(8, 64'(put_err), 64'd1, "put_err after bad put");
    check(8, 64'(global_base), 64'd150, "base kept after bad put");
    @(negedge clk); #1;
    check(8, 64'(put_err), 64'd0, "put_err one cycle only");

    // R10: same-register read and write in one cycle (local register 1)
    @(negedge clk);
    rd0_addr = 8'd1; wr_en = 1'b1; wr_addr = 8'd1; wr_data = 64'h0BAD_F00D_0000_0042;
    #1;
    check(10, rd0_data, DC, "read before edge returns old value");
    @(negedge clk);
    wr_en = 1'b0; #1;
    check(10, rd0_data, 64'h0BAD_F00D_0000_0042, "read after edge returns new value");

    // R10/R5: same-register read and write of a marginal register
    @(negedge clk);
    rd1_addr = 8'd130; wr_en = 1'b1; wr_addr = 8'd130; wr_data = 64'h1300_0000_0000_0130;
    #1;
    check(10, rd1_data, 64'd0, "marginal read before edge is zero");
    @(negedge clk);
    wr_en = 1'b0; #1;
    check(10, rd1_data, 64'h1300_0000_0000_0130, "marginal read after edge");
    check(5, 64'(local_lim), 64'd131, "limit after colliding marginal write");

    // R11: put in the same cycle as a write is ignored, write lands
    @(negedge clk);
    put_en = 1'b1; put_sel = 1'b1; put_val = 8'd160;
    wr_en = 1'b1; wr_addr = 8'd240; wr_data = 64'h2400_0000_0000_0240;
    @(negedge clk);
    put_en = 1'b0; wr_en = 1'b0; #1;
    check(11, 64'(put_err), 64'd1, "put_err on collision");
    check(11, 64'(global_base), 64'd150, "base unchanged on collision");
    rd0_addr = 8'd240; #1;
    check(11, rd0_data, 64'h2400_0000_0000_0240, "write kept on collision");

    // R1: reset again clears limits and contents
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    check(1, 64'(local_lim), 64'd0, "limit after second reset");
    check(1, 64'(global_base), 64'd255, "base after second reset");
    check(1, 64'(put_err), 64'd0, "put_err after reset");
    rd0_addr = 8'd255; rd1_addr = 8'd240; #1;
    check(1, rd0_data, 64'd0, "reg 255 after reset");
    check(1, rd1_data, 64'd0, "reg 240 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule